// File: doc/BRIEF.md
# Serial Synthesizer Command Receiver

This block is a listen-only serial slave that takes configuration words for a frequency synthesizer. A host drives a serial clock, a data line and an active-low select, using either common four-wire or three-wire slave timing. Data is captured on rising serial-clock edges while the select is low. All three serial lines are brought into the system clock domain through synchronizer flops, so the serial clock is oversampled rather than used as a clock.

Each command is 32 bits long and is sent most significant bit first. It carries a 4-bit function code, a 4-bit multiplier and a 24-bit payload. The word is acted on only when the select returns high after exactly 32 bits. The function code then steers the payload into one of five configuration registers: lower band edge, upper band edge, channel spacing, reference frequency or channel number. The multiplier nibble is kept next to the register it arrived with.

A frequency word equal to band start plus channel times spacing is produced at full precision. It follows every register change.

Top module: `synth_cmd_rx`

## Requirements
- R1: While `rst` is high on a clock edge, the five registers load their preset parameters (START_INIT, STOP_INIT, STEP_INIT, REF_INIT, CHAN_INIT). All multiplier nibbles clear to 0 and `upd_o` is low.
- R2: Bits arrive MSB first. Word bit 31 is the first bit sent. Bits [31:28] hold the function code, [27:24] the multiplier and [23:0] the payload.
- R3: Serial clock edges that occur while `ser_csn` is high do not shift data and do not count toward a frame.
- R4: A frame is committed only when `ser_csn` rises after exactly 32 rising serial-clock edges. A frame of any other length changes no register and gives no strobe.
- R5: A committed frame with code 0 writes its payload to `start_o`. Code 1 writes `stop_o`, code 2 writes `step_o`, code 3 writes `ref_o` and code 4 writes `chan_o`. Every other register keeps its value.
- R6: A committed frame with a code of 5 to 15 changes no register and gives no strobe.
- R7: `upd_o` is high for exactly one clock cycle for each register write, within 8 clock cycles of the rising edge of `ser_csn`.
- R8: Each write stores the frame's multiplier nibble in `mult_o[4*code +: 4]`, next to the register that was written.
- R9: `freq_o` is 49 bits wide and equals `start_o + chan_o * step_o` with no truncation. It is updated within 2 clock cycles of any register change.
- R10: The serial lines are sampled in the system clock domain. Each serial-clock level and each data setup must last at least 3 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_csn | input | 1 | Active-low select |
| ser_din | input | 1 | Serial data, MSB first |
| start_o | output | 24 | Band start register |
| stop_o | output | 24 | Band stop register |
| step_o | output | 24 | Channel spacing register |
| ref_o | output | 24 | Reference frequency register |
| chan_o | output | 24 | Channel number register |
| mult_o | output | 20 | Multiplier nibbles, nibble index = function code |
| upd_o | output | 1 | One-cycle write strobe |
| freq_o | output | 49 | start + chan * step |

## Verification
On every cycle, the in-line assertions check the following. The bit counter never leaves its saturating range. The shift register stays still while the select is high. The registers stay still in every cycle that has no committed frame. The strobe never lasts two cycles, and it never follows a frame with an undefined code. Only the bench scenarios can show the rest: correct MSB-first field placement, routing to the right register, the multiplier being kept per register, the full-width frequency including the all-ones case, and frames of 31 and 33 bits or stray serial edges under a high select being discarded.

// File: rtl/synth_cmd_pkg.sv
package synth_cmd_pkg;
    localparam int WORD_W = 32;
    localparam int FUNC_W = 4;
    localparam int MULT_W = 4;
    localparam int PAY_W  = 24;
    localparam int NREG   = 5;
    localparam int FREQ_W = 2 * PAY_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    typedef enum logic [FUNC_W-1:0] {
        FN_START = 4'd0,
        FN_STOP  = 4'd1,
        FN_STEP  = 4'd2,
        FN_REF   = 4'd3,
        FN_CHAN  = 4'd4
    } func_e;

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic [MULT_W-1:0] mult;
        logic [PAY_W-1:0]  pay;
    } cmd_t;

    function automatic logic code_known(input logic [FUNC_W-1:0] f);
        return f < FUNC_W'(NREG);
    endfunction

    function automatic logic [FREQ_W-1:0] calc_freq(
        input logic [PAY_W-1:0] base,
        input logic [PAY_W-1:0] chan,
        input logic [PAY_W-1:0] step
    );
        logic [FREQ_W-1:0] prod;
        prod = FREQ_W'(chan) * FREQ_W'(step);
        return prod + FREQ_W'(base);
    endfunction
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_a,
    input  logic csn_a,
    input  logic din_a,
    output logic sclk_rise,
    output logic cs_low,
    output logic cs_rise,
    output logic din_s
);
    localparam int NLINE = 3;

    logic [NLINE-1:0] stage_q [STAGES];
    logic [NLINE-1:0] last_q;
    logic [NLINE-1:0] now_s;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= 3'b010;
                end else if (g == 0) begin
                    stage_q[g] <= {din_a, csn_a, sclk_a};
                end else begin
                    stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign now_s = stage_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) last_q <= 3'b010;
        else     last_q <= now_s;
    end

    assign sclk_rise = now_s[0] & ~last_q[0];
    assign cs_low    = ~now_s[1];
    assign cs_rise   = now_s[1] & ~last_q[1];
    assign din_s     = now_s[2];
endmodule

// File: rtl/ser_shift.sv
module ser_shift
    import synth_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_rise,
    input  logic cs_low,
    input  logic cs_rise,
    input  logic din,
    output logic frame_vld,
    output cmd_t frame
);
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            cnt       <= '0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= cs_rise && (cnt == CNT_FULL);
            if (cs_rise) frame <= cmd_t'(shreg);
            if (!cs_low) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[WORD_W-2:0], din};
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_SAT); // R4
    AST_NO_SHIFT_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !cs_low |=> $stable(shreg)); // R3
endmodule

// File: rtl/cmd_route.sv
module cmd_route
    import synth_cmd_pkg::*;
#(
    parameter logic [PAY_W-1:0] START_INIT = 24'h100000,
    parameter logic [PAY_W-1:0] STOP_INIT  = 24'h200000,
    parameter logic [PAY_W-1:0] STEP_INIT  = 24'h000010,
    parameter logic [PAY_W-1:0] REF_INIT   = 24'h00A000,
    parameter logic [PAY_W-1:0] CHAN_INIT  = 24'h000000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_vld,
    input  cmd_t                     frame,
    output logic [NREG*PAY_W-1:0]    regs_flat,
    output logic [NREG*MULT_W-1:0]   mult_flat,
    output logic                     upd
);
    localparam logic [NREG*PAY_W-1:0] PRESETS =
        {CHAN_INIT, REF_INIT, STEP_INIT, STOP_INIT, START_INIT};

    logic hit;
    assign hit = frame_vld && code_known(frame.func);

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_flat[g*PAY_W +: PAY_W]   <= PRESETS[g*PAY_W +: PAY_W];
                    mult_flat[g*MULT_W +: MULT_W] <= '0;
                end else if (hit && frame.func == FUNC_W'(g)) begin
                    regs_flat[g*PAY_W +: PAY_W]   <= frame.pay;
                    mult_flat[g*MULT_W +: MULT_W] <= frame.mult;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) upd <= 1'b0;
        else     upd <= hit;
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd); // R7
    AST_IGNORE_CODE: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !code_known(frame.func)) |=> !upd); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> $stable(regs_flat)); // R4
endmodule

// File: rtl/freq_calc.sv
module freq_calc
    import synth_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PAY_W-1:0]  base,
    input  logic [PAY_W-1:0]  chan,
    input  logic [PAY_W-1:0]  step,
    output logic [FREQ_W-1:0] freq
);
    always_ff @(posedge clk) begin
        if (rst) freq <= '0;
        else     freq <= calc_freq(base, chan, step);
    end
endmodule

// File: rtl/synth_cmd_rx.sv
module synth_cmd_rx
    import synth_cmd_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [23:0]      START_INIT  = 24'h100000,
    parameter logic [23:0]      STOP_INIT   = 24'h200000,
    parameter logic [23:0]      STEP_INIT   = 24'h000010,
    parameter logic [23:0]      REF_INIT    = 24'h00A000,
    parameter logic [23:0]      CHAN_INIT   = 24'h000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_csn,
    input  logic        ser_din,
    output logic [23:0] start_o,
    output logic [23:0] stop_o,
    output logic [23:0] step_o,
    output logic [23:0] ref_o,
    output logic [23:0] chan_o,
    output logic [19:0] mult_o,
    output logic        upd_o,
    output logic [48:0] freq_o
);
    logic sclk_rise, cs_low, cs_rise, din_s;
    logic frame_vld;
    cmd_t frame;
    logic [NREG*PAY_W-1:0]  regs_flat;
    logic [NREG*MULT_W-1:0] mult_flat;

    ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_a(ser_clk), .csn_a(ser_csn), .din_a(ser_din),
        .sclk_rise(sclk_rise), .cs_low(cs_low), .cs_rise(cs_rise), .din_s(din_s)
    );

    ser_shift u_shift (
        .clk(clk), .rst(rst),
        .sclk_rise(sclk_rise), .cs_low(cs_low), .cs_rise(cs_rise), .din(din_s),
        .frame_vld(frame_vld), .frame(frame)
    );

    cmd_route #(
        .START_INIT(START_INIT), .STOP_INIT(STOP_INIT), .STEP_INIT(STEP_INIT),
        .REF_INIT(REF_INIT), .CHAN_INIT(CHAN_INIT)
    ) u_route (
        .clk(clk), .rst(rst),
        .frame_vld(frame_vld), .frame(frame),
        .regs_flat(regs_flat), .mult_flat(mult_flat), .upd(upd_o)
    );

    assign start_o = regs_flat[int'(FN_START)*PAY_W +: PAY_W];
    assign stop_o  = regs_flat[int'(FN_STOP)*PAY_W  +: PAY_W];
    assign step_o  = regs_flat[int'(FN_STEP)*PAY_W  +: PAY_W];
    assign ref_o   = regs_flat[int'(FN_REF)*PAY_W   +: PAY_W];
    assign chan_o  = regs_flat[int'(FN_CHAN)*PAY_W  +: PAY_W];
    assign mult_o  = mult_flat;

    freq_calc u_freq (
        .clk(clk), .rst(rst),
        .base(start_o), .chan(chan_o), .step(step_o),
        .freq(freq_o)
    );

    AST_FREQ_FOLLOWS_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($stable(regs_flat) && $past(!rst)) |=> $stable(freq_o)); // R9
endmodule

// File: tb/sim_synth_cmd_rx.sv
module sim_synth_cmd_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_csn = 1'b1, ser_din = 1'b0;
    logic [23:0] start_o, stop_o, step_o, ref_o, chan_o;
    logic [19:0] mult_o;
    logic        upd_o;
    logic [48:0] freq_o;

    always #2.5 clk = ~clk;

    synth_cmd_rx u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_din(ser_din),
        .start_o(start_o), .stop_o(stop_o), .step_o(step_o), .ref_o(ref_o),
        .chan_o(chan_o), .mult_o(mult_o), .upd_o(upd_o), .freq_o(freq_o)
    );

    int checks = 0, errors = 0, strobes = 0, exp_strobes = 0;
    logic [23:0] m_reg [5];
    logic [3:0]  m_mul [5];

    always @(posedge clk) if (!rst && upd_o) strobes <= strobes + 1;

    // {expect write, word}
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 4'd2, 4'd3, 24'h000100},
        {1'b1, 4'd0, 4'd1, 24'h200000},
        {1'b1, 4'd4, 4'd2, 24'h000005},
        {1'b1, 4'd3, 4'd7, 24'h00C350},
        {1'b1, 4'd1, 4'd15, 24'h3FFFFF},
        {1'b0, 4'd9, 4'd5, 24'hABCDEF},
        {1'b1, 4'd4, 4'd0, 24'hFFFFFF},
        {1'b1, 4'd2, 4'd9, 24'hFFFFFF}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R10: every serial level is held 4 system cycles
    task automatic send(input logic [31:0] w, input int nbits);
        ser_csn = 1'b0;
        wclk(4);
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 32) ? w[31-i] : 1'b0;
            wclk(4);
            ser_clk = 1'b1;
            wclk(4);
            ser_clk = 1'b0;
        end
        wclk(4);
        ser_csn = 1'b1;
        wclk(12);
    endtask

    function automatic logic [48:0] mfreq();
        return 49'(m_reg[0]) + 49'(m_reg[4]) * 49'(m_reg[2]);
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R5 start"}, 64'(start_o), 64'(m_reg[0]));
        chk({tag, " R5 stop"},  64'(stop_o),  64'(m_reg[1]));
        chk({tag, " R5 step"},  64'(step_o),  64'(m_reg[2]));
        chk({tag, " R5 ref"},   64'(ref_o),   64'(m_reg[3]));
        chk({tag, " R5 chan"},  64'(chan_o),  64'(m_reg[4]));
        chk({tag, " R8 mult"},  64'(mult_o),
            64'({m_mul[4], m_mul[3], m_mul[2], m_mul[1], m_mul[0]}));
        chk({tag, " R9 freq"},  64'(freq_o),  64'(mfreq()));
        chk({tag, " R7 strobes"}, 64'(strobes), 64'(exp_strobes));
    endtask

    task automatic model_reset();
        m_reg[0] = 24'h100000; m_reg[1] = 24'h200000; m_reg[2] = 24'h000010;
        m_reg[3] = 24'h00A000; m_reg[4] = 24'h000000;
        for (int k = 0; k < 5; k++) m_mul[k] = 4'd0;
    endtask

    initial begin
        model_reset();
        wclk(5);
        chk("R1 upd low in reset", 64'(upd_o), 64'd0);
        rst = 1'b0;
        wclk(3);
        check_all("R1 reset");

        // table walk: R2 R10 field order, R5 routing, R6 unknown code
        for (int v = 0; v < 8; v++) begin
            logic [31:0] w;
            w = VEC[v][31:0];
            send(w, 32);
            if (VEC[v][32]) begin
                m_reg[w[31:28]] = w[23:0];
                m_mul[w[31:28]] = w[27:24];
                exp_strobes++;
            end
            check_all($sformatf("vec%0d R2 R6", v));
        end

        // R4: short frame discarded
        send({4'd4, 4'd1, 24'h000001}, 31);
        check_all("R4 31 bits");
        // R4: long frame discarded
        send({4'd0, 4'd1, 24'h000777}, 33);
        check_all("R4 33 bits");

        // R3: stray serial edges while select high, then a normal frame
        for (int i = 0; i < 5; i++) begin
            ser_din = 1'b1; wclk(4); ser_clk = 1'b1; wclk(4); ser_clk = 1'b0;
        end
        wclk(8);
        check_all("R3 idle edges");
        send({4'd4, 4'd6, 24'h000003}, 32);
        m_reg[4] = 24'h000003; m_mul[4] = 4'd6; exp_strobes++;
        check_all("R3 after stray");

        // R1: reset mid-run restores presets
        @(negedge clk); rst = 1'b1; wclk(3); rst = 1'b0; wclk(3);
        model_reset();
        check_all("R1 re-reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #900000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule